// File: doc/BRIEF.md
# Noise-Filtered Pin Edge Qualifier

This block watches an asynchronous timer input pin and turns its level changes into single-cycle edge strobes for the counter and capture logic nearby. The pin is first brought into the system clock domain by a short synchroniser. After that it is sampled only on cycles where a sampling enable is active. A new level is accepted only when it appears on consecutive samples, so glitches shorter than the confirmation window never reach the output.

The sampling rate depends on how the pin is used. When the pin drives the counter as its count clock, the undivided peripheral clock enable paces sampling. When the pin is a capture trigger, the prescaled count clock enable paces it instead. A two-bit select picks falling, rising, both or no edges. While the run input is low, no strobe is produced.

The filtered level starts low at reset. If the pin is already high at the first enable, the detector therefore reports one rising edge. After a stop and a later restart this does not happen again, because the filtered level follows the pin while the block is stopped.

Top module: `pin_edge_qual`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `edge_o` is low.
- R2: A new level is accepted only after it has been seen on two successive sampling enables. A level that is present on only one sample produces no strobe.
- R3: When `cnt_mode_i` is 1 (pin used as count clock), the pin is sampled only in cycles where `pclk_en_i` is 1. `pscl_en_i` has no effect.
- R4: When `cnt_mode_i` is 0 (pin used as capture trigger), the pin is sampled only in cycles where `pscl_en_i` is 1. `pclk_en_i` has no effect.
- R5: `edge_sel_i` encodes 2'b00 = falling only, 2'b01 = rising only, 2'b10 = both edges, 2'b11 = no edges. Only accepted changes that match the selection produce a strobe.
- R6: At the first assertion of `run_i` after reset, if the pin is already high and rising or both edges are selected, exactly one rising strobe is produced once the high level has been confirmed.
- R7: When `run_i` is raised again after a stop, a pin that is already high produces no strobe.
- R8: While `run_i` is low, no strobe is produced, whatever the pin does.
- R9: Every strobe lasts exactly one clock cycle. With the sampling enable held high, a pin change applied between clock edges raises `edge_o` in the fourth cycle after the change: two cycles in the synchroniser, one for the first sample and one for the confirming sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw asynchronous timer pin |
| run_i | input | 1 | Timer run (1) or stop (0) |
| cnt_mode_i | input | 1 | 1: pin is the count clock; 0: pin is a capture trigger |
| pclk_en_i | input | 1 | Undivided peripheral clock enable |
| pscl_en_i | input | 1 | Prescaled count clock enable |
| edge_sel_i | input | 2 | Edge selection, encoded as in R5 |
| edge_o | output | 1 | Single-cycle qualified edge strobe |

## Verification
A wrong filtered level shows up at the port as a missing strobe or an extra one. This is clearest around the first enable and around restarts: a level stuck high suppresses the phantom edge of R6, and a level that fails to follow the pin while stopped brings a phantom back under R7. A corrupted sample history appears as an accepted one-sample glitch, or as a strobe that is one sampling period late. The bench compares `edge_o` every cycle against an independent cycle model, so such faults are reported within a few sampling periods of the stimulus that exposes them.

// File: rtl/pin_edge_qual_pkg.sv
package pin_edge_qual_pkg;
  typedef enum logic [1:0] {
    SEL_FALL = 2'b00,
    SEL_RISE = 2'b01,
    SEL_BOTH = 2'b10,
    SEL_NONE = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/pin_edge_qual_sync.sv
module pin_edge_qual_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[g] <= 1'b0;
        else if (g == 0) ff_q[g] <= d_i;
        else ff_q[g] <= ff_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/pin_edge_qual_filter.sv
module pin_edge_qual_filter #(
  parameter int unsigned CONFIRM = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic smp_en_i,
  input  logic run_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HW = CONFIRM - 1;

  logic [HW-1:0] hist_q;
  logic          lvl_q;
  logic          armed_q;  // first enable after reset consumed
  logic [HW:0]   hist_ext;
  logic          confirm;

  assign hist_ext = {hist_q, lvl_i};
  assign confirm  = run_i && smp_en_i && (hist_q == {HW{lvl_i}}) && (lvl_i != lvl_q);
  assign rise_o   = confirm && lvl_i;
  assign fall_o   = confirm && !lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '0;
      lvl_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (!run_i) begin
      // once past the first enable, track the pin while stopped
      if (armed_q) begin
        hist_q <= {HW{lvl_i}};
        lvl_q  <= lvl_i;
      end
    end else begin
      armed_q <= 1'b1;
      if (smp_en_i) begin
        hist_q <= hist_ext[HW-1:0];
        if (confirm) lvl_q <= lvl_i;
      end
    end
  end
endmodule

// File: rtl/pin_edge_qual_strobe.sv
module pin_edge_qual_strobe
  import pin_edge_qual_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic [1:0] sel_i,
  output logic       edge_o
);
  logic hit;
  logic edge_q;

  always_comb begin
    unique case (edge_sel_e'(sel_i))
      SEL_FALL: hit = fall_i;
      SEL_RISE: hit = rise_i;
      SEL_BOTH: hit = rise_i | fall_i;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_q <= 1'b0;
    else edge_q <= hit;
  end

  assign edge_o = edge_q;
endmodule

// File: rtl/pin_edge_qual.sv
module pin_edge_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CONFIRM     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       run_i,
  input  logic       cnt_mode_i,
  input  logic       pclk_en_i,
  input  logic       pscl_en_i,
  input  logic [1:0] edge_sel_i,
  output logic       edge_o
);
  logic pin_sync;
  logic smp_en;
  logic rise;
  logic fall;

  assign smp_en = cnt_mode_i ? pclk_en_i : pscl_en_i;

  pin_edge_qual_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  pin_edge_qual_filter #(.CONFIRM(CONFIRM)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (pin_sync),
    .smp_en_i(smp_en),
    .run_i   (run_i),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  pin_edge_qual_strobe u_strb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(rise),
    .fall_i(fall),
    .sel_i (edge_sel_i),
    .edge_o(edge_o)
  );
endmodule

// File: rtl/pin_edge_qual_chk.sv
module pin_edge_qual_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_i,
  input logic       cnt_mode_i,
  input logic       pclk_en_i,
  input logic       pscl_en_i,
  input logic [1:0] edge_sel_i,
  input logic       edge_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) $rose(rst_ni) |-> !edge_o); // R1
  AST_CNT_NEEDS_PCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_mode_i && !pclk_en_i) |=> !edge_o); // R3
  AST_CAP_NEEDS_PSCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_mode_i && !pscl_en_i) |=> !edge_o); // R4
  AST_SEL_NONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == 2'b11) |=> !edge_o); // R5
  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !edge_o); // R8
  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o); // R9
endmodule

bind pin_edge_qual pin_edge_qual_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_i),
  .cnt_mode_i(cnt_mode_i),
  .pclk_en_i (pclk_en_i),
  .pscl_en_i (pscl_en_i),
  .edge_sel_i(edge_sel_i),
  .edge_o    (edge_o)
);

// File: tb/pin_edge_qual_tb.sv
module pin_edge_qual_tb_top;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0, run = 1'b0, cnt_mode = 1'b1, pclk_en = 1'b1, pscl_en = 1'b0;
  logic [1:0] sel = 2'b10;
  logic       edge_s;

  int checks = 0, errors = 0, edge_cnt = 0;
  bit model_on = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pin_edge_qual dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .run_i(run), .cnt_mode_i(cnt_mode),
    .pclk_en_i(pclk_en), .pscl_en_i(pscl_en), .edge_sel_i(sel), .edge_o(edge_s)
  );

  // independent cycle model built from R2..R9
  logic m_s1, m_s2, m_prev, m_lvl, m_first_done, m_edge;
  function automatic logic sel_hit(input logic [1:0] s, input logic rise);
    case (s)
      2'b00: return !rise;
      2'b01: return rise;
      2'b10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_lvl <= 0; m_first_done <= 0; m_edge <= 0;
    end else begin
      logic en, ok;
      en = cnt_mode ? pclk_en : pscl_en;
      ok = run && en && (m_prev == m_s2) && (m_s2 != m_lvl);
      m_s1 <= pin; m_s2 <= m_s1;
      m_edge <= ok && sel_hit(sel, m_s2);
      if (!run) begin
        if (m_first_done) begin m_prev <= m_s2; m_lvl <= m_s2; end
      end else begin
        m_first_done <= 1'b1;
        if (en) begin m_prev <= m_s2; if (ok) m_lvl <= m_s2; end
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_cnt(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) check("R9 cycle model", edge_s, m_edge);
    if (rst_n && edge_s) edge_cnt++;
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset, pin high already (sets up phantom-edge case)
    pin = 1'b1;
    step(2);
    check("R1 in reset", edge_s, 1'b0);
    rst_n = 1'b1;
    step(1);
    check("R1 after release", edge_s, 1'b0);
    model_on = 1'b1;
    step(4);
    // R6: first enable, pin already high, rising selected
    sel = 2'b01; edge_cnt = 0; run = 1'b1;
    step(12);
    check_cnt("R6 phantom rise", edge_cnt, 1);
    // R9 latency: pin falls, both edges, expect strobe 4 cycles later
    sel = 2'b10; pin = 1'b0;
    step(3); check("R9 not yet", edge_s, 1'b0);
    step(1); check("R9 latency", edge_s, 1'b1);
    step(1); check("R9 one cycle", edge_s, 1'b0);
    // R7: stop, raise pin, restart
    run = 1'b0; step(2); pin = 1'b1; step(6);
    edge_cnt = 0; run = 1'b1; step(12);
    check_cnt("R7 no edge on restart", edge_cnt, 0);
    // R8: toggles while stopped
    run = 1'b0; edge_cnt = 0;
    for (int i = 0; i < 10; i++) begin pin = ~pin; step(4); end
    check_cnt("R8 stopped", edge_cnt, 0);
    run = 1'b1; pin = 1'b0; step(10);
    // R2: one-cycle glitch rejected, two-cycle pulse accepted
    edge_cnt = 0; pin = 1'b1; step(1); pin = 1'b0; step(10);
    check_cnt("R2 glitch rejected", edge_cnt, 0);
    edge_cnt = 0; pin = 1'b1; step(2); pin = 1'b0; step(10);
    check_cnt("R2 two samples accepted", edge_cnt, 2);
    // R5: none, falling-only, rising-only
    sel = 2'b11; edge_cnt = 0; pin = 1'b1; step(8); pin = 1'b0; step(8);
    check_cnt("R5 none", edge_cnt, 0);
    sel = 2'b00; edge_cnt = 0; pin = 1'b1; step(8); pin = 1'b0; step(8);
    check_cnt("R5 falling only", edge_cnt, 1);
    sel = 2'b01; edge_cnt = 0; pin = 1'b1; step(8); pin = 1'b0; step(8);
    check_cnt("R5 rising only", edge_cnt, 1);
    // R3: count mode ignores pscl_en
    sel = 2'b10; cnt_mode = 1'b1; pclk_en = 1'b0; pscl_en = 1'b1; edge_cnt = 0;
    pin = 1'b1; step(8); pin = 1'b0; step(8);
    check_cnt("R3 no pclk_en", edge_cnt, 0);
    // R4: capture mode paced by pscl_en, pclk_en ignored
    cnt_mode = 1'b0; pclk_en = 1'b1; pscl_en = 1'b0; edge_cnt = 0;
    pin = 1'b1; step(8); pin = 1'b0; step(8);
    check_cnt("R4 no pscl_en", edge_cnt, 0);
    edge_cnt = 0;
    for (int i = 0; i < 40; i++) begin
      pscl_en = (i % 4 == 0);
      if (i == 2) pin = 1'b1;
      if (i == 22) pin = 1'b0;
      step(1);
    end
    check_cnt("R4 prescaled sampling", edge_cnt, 2);
    // R4/R2: pulse shorter than sampling period rejected in capture mode
    edge_cnt = 0;
    for (int i = 0; i < 40; i++) begin
      pscl_en = (i % 4 == 0);
      if (i == 5) pin = 1'b1;
      if (i == 10) pin = 1'b0;
      step(1);
    end
    check_cnt("R2 short pulse vs prescaled sampling", edge_cnt, 0);
    // random phase, checked by the cycle model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 5) == 0) pin = ~pin;
      pclk_en = ($urandom_range(0, 3) != 0);
      pscl_en = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 99) == 0) cnt_mode = ~cnt_mode;
      if ($urandom_range(0, 79) == 0) run = ~run;
      if ($urandom_range(0, 59) == 0) sel = 2'($urandom);
      step(1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule